// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block decides which interrupt a small CPU takes next. It watches three kinds of request. The first is a maskable external pin, which is active low. The second is a second external pin that only a special mask can hold off; this is the pseudo-non-maskable request. The third is a set of internal peripheral lines, and each line has its own enable bit. Fixed priority picks one winner. The block presents that winner to the CPU as a request strobe and as the 16-bit address of the winner's two-byte vector slot.

Two mask bits live inside the block. I holds off every maskable source. X holds off the pseudo-non-maskable source; it is set at reset, and after that software can only clear it. A small pin control register selects how the maskable pin is sensed: active-low level or falling edge. The same register can also disconnect that pin. When the CPU acknowledges a request, the block sets the masks itself. A return-from-interrupt strobe loads the masks from values the CPU has unstacked. Both external pins go through a two-flop synchronizer first. Register stacking and the service routines are the CPU's job, not this block's.

Top module: `intc_ctrl`

## Requirements
- R1: After reset, `int_req` is 0, `int_vec` is 16'h0000, `i_mask` and `x_mask` are 1, and `ctrl_rdata` reads 8'h40.
- R2: Control bit 7 = 0 selects level mode. In that mode, with bit 6 = 1 and I = 0, a low on `ext_irq_n` drives a request at slot 16'hFFF2 within three clocks. The request ends within three clocks after the pin goes high.
- R3: Control bit 7 = 1 selects edge mode. A falling edge on `ext_irq_n` sets a sticky flag, and the flag requests at 16'hFFF2 even after the pin goes high. Only `flag_clr` ends the flag. If a new edge is captured in the same cycle as `flag_clr`, the flag stays set.
- R4: Control bit 6 = 0 disconnects `ext_irq_n`. In that state the pin never raises a request in either mode. A falling edge seen while the pin is disconnected is not remembered.
- R5: While I = 1, the external pin and all peripherals raise no request. A pending pseudo-non-maskable request with X = 0 is still presented.
- R6: X is 1 after reset. A mask write of 0 to X clears it. A mask write of 1 to X leaves X unchanged. A mask write sets I to the written value.
- R7: Fixed priority by vector address, highest address wins. The pseudo-non-maskable source is at 16'hFFF4. The external pin is at 16'hFFF2. Peripheral j is at 16'hFFF0 - 2*j. When nothing is eligible, `int_vec` reads 16'h0000.
- R8: Peripheral j requests only when both `periph_req[j]` and `periph_en[j]` are 1.
- R9: `int_ack` while `int_req` is 1 sets I on the next clock. If the winner is the pseudo-non-maskable source, the ack also sets X and clears that source's pending flag.
- R10: `rti` loads I from `rti_i` and loads X with X AND `rti_x`, so X is never raised by `rti`.
- R11: A falling edge on `pnm_irq_n` is held pending until it is acknowledged, even after the pin returns high.
- R12: When mask updates collide in one cycle, an accepted ack wins over `rti`, and `rti` wins over a mask write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_n | input | 1 | Maskable external request pin, active low |
| pnm_irq_n | input | 1 | Pseudo-non-maskable pin, falling edge |
| periph_req | input | NPER | Internal peripheral request lines |
| periph_en | input | NPER | Per-peripheral enable bits |
| ctrl_we | input | 1 | Write strobe for the pin control register |
| ctrl_wdata | input | 8 | Control data: bit 7 edge mode, bit 6 pin connect |
| ctrl_rdata | output | 8 | Current pin control register |
| mask_we | input | 1 | Write strobe for the mask bits |
| mask_wdata_i | input | 1 | New I value |
| mask_wdata_x | input | 1 | New X value (clear only) |
| flag_clr | input | 1 | Clears the external edge flag |
| int_ack | input | 1 | CPU accepts the presented request |
| rti | input | 1 | Return-from-interrupt strobe |
| rti_i | input | 1 | Unstacked I value |
| rti_x | input | 1 | Unstacked X value |
| int_req | output | 1 | A request is presented |
| int_vec | output | 16 | Vector slot address of the winner |
| i_mask | output | 1 | Current I bit |
| x_mask | output | 1 | Current X bit |

## Verification
Two things can land in the same cycle: a write to `flag_clr` and the capture of a new falling edge on the maskable pin. The bench provokes this by pulling the pin low and then asserting `flag_clr` exactly on the third clock, which is when the synchronized edge sets the flag. The flag must survive, so a request is expected afterwards. A second `flag_clr` with no edge must then remove the request. The same treatment is given to an ack that lands with `rti`, and to `rti` that lands with a mask write; the I bit that results from each is compared with the stated order.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int CTRL_W = 8;

  typedef struct packed {
    logic       edge_mode;
    logic       pin_on;
    logic [5:0] spare;
  } pin_ctrl_t;

  localparam pin_ctrl_t CTRL_RST = '{edge_mode: 1'b0, pin_on: 1'b1, spare: 6'd0};

  function automatic logic [15:0] slot_addr(input logic [15:0] top, input int unsigned k);
    return top - 16'(2 * k);
  endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int           W    = 2,
  parameter logic [W-1:0] IDLE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= IDLE;
      s2_q <= IDLE;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/intc_fall_flag.sv
module intc_fall_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic arm,
  input  logic clr,
  output logic flag
);
  logic prev_q, flag_q, flag_d, fall;

  assign fall = prev_q & ~pin_s & arm;

  always_comb begin
    flag_d = flag_q;
    if (fall)     flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      prev_q <= pin_s;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  // R3 / R11: a captured edge stays until cleared
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr |=> flag_q);
  // R4: the flag only rises from an armed capture
  a_r4_armed_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(arm));
endmodule

// File: rtl/intc_mask.sv
module intc_mask (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  input  logic ack_pnm,
  input  logic rti,
  input  logic rti_i,
  input  logic rti_x,
  input  logic we,
  input  logic wi,
  input  logic wx,
  output logic i_q,
  output logic x_q
);
  logic i_d, x_d;

  always_comb begin
    i_d = i_q;
    x_d = x_q;
    if (ack) begin
      i_d = 1'b1;
      if (ack_pnm) x_d = 1'b1;
    end else if (rti) begin
      i_d = rti_i;
      x_d = x_q & rti_x;
    end else if (we) begin
      i_d = wi;
      x_d = x_q & wx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_q <= 1'b1;
      x_q <= 1'b1;
    end else begin
      i_q <= i_d;
      x_q <= x_d;
    end
  end

  // R6: software never raises X
  a_r6_x_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(x_q) |-> $past(ack_pnm));
  // R9: acceptance masks further maskable requests
  a_r9_ack_sets_i: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> i_q);
  // R10: return restores I when no ack collides
  a_r10_rti_loads_i: assert property (@(posedge clk) disable iff (!rst_n)
    rti && !ack |=> i_q == $past(rti_i));
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int N  = 10,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          valid,
  output logic [IW-1:0] idx
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) begin
        valid = 1'b1;
        idx   = IW'(k);
      end
    end
  end
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int          NPER    = 8,
  parameter logic [15:0] VEC_TOP = 16'hFFF4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_irq_n,
  input  logic              pnm_irq_n,
  input  logic [NPER-1:0]   periph_req,
  input  logic [NPER-1:0]   periph_en,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_rdata,
  input  logic              mask_we,
  input  logic              mask_wdata_i,
  input  logic              mask_wdata_x,
  input  logic              flag_clr,
  input  logic              int_ack,
  input  logic              rti,
  input  logic              rti_i,
  input  logic              rti_x,
  output logic              int_req,
  output logic [15:0]       int_vec,
  output logic              i_mask,
  output logic              x_mask
);
  localparam int NSRC = NPER + 2;
  localparam int IW   = $clog2(NSRC);

  // reset: asserted at once, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  // pin control register
  pin_ctrl_t ctrl_q, ctrl_d;
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) ctrl_d = pin_ctrl_t'(ctrl_wdata);
  end
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) ctrl_q <= CTRL_RST;
    else          ctrl_q <= ctrl_d;
  end
  assign ctrl_rdata = ctrl_q;

  // pin synchronizers: bit 1 pseudo-non-maskable, bit 0 maskable
  logic [1:0] pins_s;
  intc_sync #(.W(2), .IDLE(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .d({pnm_irq_n, ext_irq_n}), .q(pins_s)
  );

  logic ack_take, ack_pnm, ext_flag, pnm_flag;

  intc_fall_flag u_ext_flag (
    .clk(clk), .rst_n(rst_i_n), .pin_s(pins_s[0]),
    .arm(ctrl_q.edge_mode & ctrl_q.pin_on), .clr(flag_clr), .flag(ext_flag)
  );

  intc_fall_flag u_pnm_flag (
    .clk(clk), .rst_n(rst_i_n), .pin_s(pins_s[1]),
    .arm(1'b1), .clr(ack_pnm), .flag(pnm_flag)
  );

  // mask bits
  logic i_q, x_q;
  intc_mask u_mask (
    .clk(clk), .rst_n(rst_i_n), .ack(ack_take), .ack_pnm(ack_pnm),
    .rti(rti), .rti_i(rti_i), .rti_x(rti_x),
    .we(mask_we), .wi(mask_wdata_i), .wx(mask_wdata_x),
    .i_q(i_q), .x_q(x_q)
  );
  assign i_mask = i_q;
  assign x_mask = x_q;

  // eligible sources, index 0 highest address
  logic            ext_act;
  logic [NSRC-1:0] src;
  assign ext_act = ctrl_q.pin_on & (ctrl_q.edge_mode ? ext_flag : ~pins_s[0]);
  assign src[0]  = pnm_flag & ~x_q;
  assign src[1]  = ext_act & ~i_q;
  for (genvar j = 0; j < NPER; j++) begin : g_per
    assign src[j+2] = periph_req[j] & periph_en[j] & ~i_q;
  end

  logic          win_v;
  logic [IW-1:0] win_idx;
  intc_prio #(.N(NSRC)) u_prio (.req(src), .valid(win_v), .idx(win_idx));

  assign int_req  = win_v;
  assign int_vec  = win_v ? slot_addr(VEC_TOP, 32'(win_idx)) : 16'h0000;
  assign ack_take = int_ack & win_v;
  assign ack_pnm  = ack_take & (win_idx == '0);

  // R5: with I set only the top slot may be offered
  a_r5_i_blocks: assert property (@(posedge clk) disable iff (!rst_i_n)
    i_q && int_req |-> int_vec == VEC_TOP);
  // R7: an eligible pseudo-non-maskable request always wins
  a_r7_pnm_wins: assert property (@(posedge clk) disable iff (!rst_i_n)
    pnm_flag && !x_q |-> int_req && int_vec == VEC_TOP);
  // R4: a disconnected pin cannot take the external slot
  a_r4_disc_pin: assert property (@(posedge clk) disable iff (!rst_i_n)
    !ctrl_q.pin_on |-> int_vec != slot_addr(VEC_TOP, 1));
endmodule

// File: tb/intc_ctrl_tb.sv
module intc_ctrl_tb;
  localparam int NPER = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, ext_irq_n, pnm_irq_n, ctrl_we, mask_we, mask_wdata_i, mask_wdata_x;
  logic flag_clr, int_ack, rti, rti_i, rti_x, int_req, i_mask, x_mask;
  logic [NPER-1:0] periph_req, periph_en;
  logic [7:0] ctrl_wdata, ctrl_rdata;
  logic [15:0] int_vec;

  intc_ctrl #(.NPER(NPER)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .pnm_irq_n(pnm_irq_n),
    .periph_req(periph_req), .periph_en(periph_en),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .mask_we(mask_we), .mask_wdata_i(mask_wdata_i), .mask_wdata_x(mask_wdata_x),
    .flag_clr(flag_clr), .int_ack(int_ack), .rti(rti), .rti_i(rti_i), .rti_x(rti_x),
    .int_req(int_req), .int_vec(int_vec), .i_mask(i_mask), .x_mask(x_mask)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_we = 1; ctrl_wdata = v; tick(); ctrl_we = 0;
  endtask

  task automatic wr_mask(input logic i, input logic x);
    mask_we = 1; mask_wdata_i = i; mask_wdata_x = x; tick(); mask_we = 0;
  endtask

  task automatic pnm_pulse();
    pnm_irq_n = 0; tick(4); pnm_irq_n = 1; tick();
  endtask

  task automatic ack();
    int_ack = 1; tick(); int_ack = 0;
  endtask

  function automatic logic [16:0] model(input logic pnm, input logic x, input logic ext,
                                        input logic i, input logic [NPER-1:0] pr);
    if (pnm && !x) return {1'b1, 16'hFFF4};
    if (i) return 17'h0;
    if (ext) return {1'b1, 16'hFFF2};
    for (int j = 0; j < NPER; j++)
      if (pr[j]) return {1'b1, 16'(16'hFFF0 - 16'(2 * j))};
    return 17'h0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; ext_irq_n = 1; pnm_irq_n = 1; periph_req = '0; periph_en = '0;
    ctrl_we = 0; ctrl_wdata = '0; mask_we = 0; mask_wdata_i = 0; mask_wdata_x = 0;
    flag_clr = 0; int_ack = 0; rti = 0; rti_i = 0; rti_x = 0;
    tick(3); rst_n = 1; tick(4);

    // R1 reset state
    check("R1 int_req", int_req, 0);
    check("R1 int_vec", int_vec, 16'h0000);
    check("R1 i_mask", i_mask, 1);
    check("R1 x_mask", x_mask, 1);
    check("R1 ctrl", ctrl_rdata, 8'h40);

    // R6 X write rules
    wr_mask(0, 1);
    check("R6 x kept on write 1", x_mask, 1);
    check("R6 i written", i_mask, 0);
    wr_mask(0, 0);
    check("R6 x cleared", x_mask, 0);
    wr_mask(0, 1);
    check("R6 x not set by sw", x_mask, 0);

    // R2 level mode
    ext_irq_n = 0; tick(3);
    check("R2 level req", {int_req, int_vec}, {1'b1, 16'hFFF2});
    ext_irq_n = 1; tick(3);
    check("R2 level release", int_req, 0);

    // R4 disconnected pin
    wr_ctrl(8'h00);
    ext_irq_n = 0; tick(4);
    check("R4 level disc", int_req, 0);
    wr_ctrl(8'h80);
    ext_irq_n = 1; tick(3); ext_irq_n = 0; tick(4);
    check("R4 edge disc", int_req, 0);
    wr_ctrl(8'hC0); ext_irq_n = 1; tick(3);
    check("R4 no stored edge", int_req, 0);

    // R3 edge mode, sticky flag
    ext_irq_n = 0; tick(4);
    check("R3 edge req", {int_req, int_vec}, {1'b1, 16'hFFF2});
    ext_irq_n = 1; tick(4);
    check("R3 sticky", int_req, 1);
    flag_clr = 1; tick(); flag_clr = 0;
    check("R3 cleared", int_req, 0);
    ext_irq_n = 0; tick(4); ext_irq_n = 1; tick(4);
    // collision: clear lands on the capture cycle of a new edge
    ext_irq_n = 0; tick(2); flag_clr = 1; tick(); flag_clr = 0;
    check("R3 set beats clear", int_req, 1);
    ext_irq_n = 1; tick(3);
    flag_clr = 1; tick(); flag_clr = 0;
    check("R3 plain clear", int_req, 0);
    wr_ctrl(8'h40); tick(2);

    // R8 enables
    periph_req = '1; periph_en = '0; tick();
    check("R8 disabled", int_req, 0);
    periph_en = 8'h08; tick();
    check("R8 one enabled", {int_req, int_vec}, {1'b1, 16'hFFEA});

    // R7 priority
    ext_irq_n = 0; tick(3);
    check("R7 ext over periph", int_vec, 16'hFFF2);
    pnm_pulse();
    check("R7 pnm wins", {int_req, int_vec}, {1'b1, 16'hFFF4});

    // R9 ack of pnm, R11 pending cleared
    ack();
    check("R9 i set", i_mask, 1);
    check("R9 x set", x_mask, 1);
    check("R11 pnm flag consumed", int_req, 0);

    // R10 rti
    rti = 1; rti_i = 0; rti_x = 0; tick(); rti = 0;
    check("R10 i", i_mask, 0);
    check("R10 x", x_mask, 0);
    check("R10 req again", int_vec, 16'hFFF2);
    ack();
    check("R9 maskable ack i", i_mask, 1);
    check("R9 maskable ack x", x_mask, 0);

    // R5 I blocks maskable, pnm still taken
    tick(2);
    check("R5 masked", int_req, 0);
    pnm_pulse(); tick(2);
    check("R11 pnm held", {int_req, int_vec}, {1'b1, 16'hFFF4});
    check("R5 pnm through I", i_mask, 1);
    ack();
    wr_mask(1, 0);
    rti = 1; rti_i = 0; rti_x = 1; tick(); rti = 0;
    check("R10 x not raised", x_mask, 0);
    check("R10 i restored", i_mask, 0);

    // R12 collisions
    int_ack = 1; rti = 1; rti_i = 0; tick(); int_ack = 0; rti = 0;
    check("R12 ack over rti", i_mask, 1);
    rti = 1; rti_i = 0; mask_we = 1; mask_wdata_i = 1; mask_wdata_x = 0;
    tick(); rti = 0; mask_we = 0;
    check("R12 rti over write", i_mask, 0);

    ext_irq_n = 1; periph_req = '0; periph_en = '0; tick(3);

    // random phase, level mode, R7/R8/R5/R2 against model
    for (int it = 0; it < 300; it++) begin
      logic ib, eb;
      logic [NPER-1:0] pr, pe;
      ib = 1'($urandom); eb = 1'($urandom);
      pr = NPER'($urandom); pe = NPER'($urandom);
      periph_req = pr; periph_en = pe; ext_irq_n = ~eb;
      wr_mask(ib, 0);
      tick(3);
      check("R7 random", {int_req, int_vec}, model(1'b0, 1'b0, eb, ib, pr & pe));
      if (int_req && 1'($urandom)) begin
        ack();
        check("R9 random ack", i_mask, 1);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule